// File: doc/BRIEF.md
# Page Write Buffer with Program Timer

This block sits behind a serial memory command decoder. It gathers the data bytes of one write command into a small page buffer. When chip select is released in a legal place and writing is allowed, it runs a self-timed programming cycle that commits the buffered bytes to the storage array. The decoder tells it when a command opens, and passes the start address. It also signals each complete data byte, the rise of chip select, whether the bit counter sits exactly on a byte boundary, and whether the protection logic allows the write. The block answers with a busy flag, one array write strobe per stored byte and a one-cycle completion pulse.

The page holds four bytes, selected by the two low address bits. Each received byte advances only those two bits. The upper address bits stay fixed, so a fifth byte lands on the first byte's position and replaces it. Once the cycle is started, the block steps through the four positions in ascending order, one per clock (state COMMIT), and strobes the array for each position that holds a byte. It then waits a fixed number of system clocks (state WAIT) before it returns to IDLE. The states are IDLE, COLLECT, COMMIT and WAIT. The transitions are:
- open: IDLE to COLLECT on a command start.
- launch: COLLECT to COMMIT on a qualified chip-select rise.
- discard: COLLECT to IDLE on any other chip-select rise.
- drain: COMMIT to WAIT after the last position.
- finish: WAIT to IDLE when the timer expires.

Top module: `pgbuf_prog`

## Requirements
- R1: A command start in IDLE opens a command, latches the start address and empties the buffer. Every byte received in COLLECT is kept, and all kept bytes are committed in a single programming cycle.
- R2: A received byte is stored at the position given by the current two low address bits, and those bits then advance by one modulo 4. The array address of every write carries the upper address bits of the start address unchanged, with the position in bits 1:0.
- R3: When more than four bytes arrive, a later byte replaces the earlier byte at the same position, so the last byte written to a position is the one committed.
- R4: A programming cycle starts only on a chip-select rise in COLLECT that has at_boundary=1, wr_permit=1 and at least one byte received. A rise with no bytes received returns to IDLE and writes nothing.
- R5: A chip-select rise with wr_permit=0 discards the command: the block returns to IDLE, makes no array write and keeps busy at 0.
- R6: A chip-select rise with at_boundary=0 (partial byte) aborts the command with no array write and busy kept at 0.
- R7: During COMMIT, positions 0,1,2,3 are visited in that order, one per clock. arr_we is 1 only for positions that received a byte, and arr_we is never 1 while busy is 0.
- R8: busy rises in the clock after a qualifying chip-select rise. It stays 1 for exactly 4 + PROG_CLKS clocks and then returns to 0.
- R9: cycle_done is a single-clock pulse in the last clock in which busy is 1.
- R10: While busy is 1, command start, byte strobes and chip-select rises have no effect.
- R11: After reset, busy, arr_we and cycle_done are 0 and the block is in IDLE.
- R12: Byte strobes in IDLE, before any command start, are ignored and never reach the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Pulse: a write command has been decoded |
| start_addr | input | ADDR_W | Start address, valid with cmd_start |
| byte_vld | input | 1 | Pulse: a complete data byte is present |
| byte_data | input | DATA_W | Data byte, valid with byte_vld |
| cs_rise | input | 1 | Pulse: chip select has been released |
| at_boundary | input | 1 | 1 when the serial bit count is at an exact byte boundary |
| wr_permit | input | 1 | 1 when enable and protection allow the write |
| busy | output | 1 | Programming cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| cycle_done | output | 1 | Pulse: programming cycle complete |

## Verification
On every cycle, the assertions check that the busy interval cannot break early, that the completion pulse lasts one clock and ends busy, that array strobes occur only while busy, and that no byte enters the buffer during a cycle. Only the bench scenarios can show the rest: the page wrap and its overwrite, the order of the committed addresses, the discard and abort outcomes, and the exact busy length. For these, a behavioural model is compared with the outputs every clock, and writes are counted per command.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
    typedef enum logic [1:0] {
        PG_IDLE    = 2'd0,
        PG_COLLECT = 2'd1,
        PG_COMMIT  = 2'd2,
        PG_WAIT    = 2'd3
    } pg_state_t;
endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 wr,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [DATA_W-1:0]    rd_data,
    output logic [(1<<IDX_W)-1:0] valid
);
    localparam int SLOTS = 1 << IDX_W;

    logic [DATA_W-1:0] slot_d [SLOTS];
    logic              slot_v [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_d[i] <= '0;
                slot_v[i] <= 1'b0;
            end else if (clear) begin
                slot_v[i] <= 1'b0;
            end else if (wr && (wr_idx == IDX_W'(i))) begin
                slot_d[i] <= wr_data;
                slot_v[i] <= 1'b1;
            end
        end
    end

    always_comb begin
        for (int k = 0; k < SLOTS; k++) valid[k] = slot_v[k];
        rd_data = slot_d[rd_idx];
    end
endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer #(
    parameter int PROG_CLKS = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CNT_W = (PROG_CLKS > 1) ? $clog2(PROG_CLKS) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CLKS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= LOAD;
        else if (!run)      cnt_q <= LOAD;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign last = run && (cnt_q == '0);

    AST_TIMER_NO_EARLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last) |=> run); // R8
endmodule

// File: rtl/pgbuf_prog.sv
module pgbuf_prog
    import pgbuf_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 2,
    parameter int PROG_CLKS = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              cs_rise,
    input  logic              at_boundary,
    input  logic              wr_permit,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              cycle_done
);
    localparam int SLOTS = 1 << PAGE_BITS;
    localparam int HI_W  = ADDR_W - PAGE_BITS;

    pg_state_t             state_q, state_d;
    logic [HI_W-1:0]       page_q;
    logic [PAGE_BITS-1:0]  ptr_q, slot_q;
    logic [SLOTS-1:0]      have;
    logic [DATA_W-1:0]     rd_data;
    logic                  st_clear, st_wr, launch, tmr_run, tmr_last;

    assign st_clear = (state_q == PG_IDLE) && cmd_start;
    assign st_wr    = (state_q == PG_COLLECT) && byte_vld && !cs_rise;
    assign launch   = (state_q == PG_COLLECT) && cs_rise && at_boundary
                      && wr_permit && (|have);

    pgbuf_store #(.DATA_W(DATA_W), .IDX_W(PAGE_BITS)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(st_clear), .wr(st_wr),
        .wr_idx(ptr_q), .wr_data(byte_data), .rd_idx(slot_q),
        .rd_data(rd_data), .valid(have)
    );

    pgbuf_timer #(.PROG_CLKS(PROG_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .last(tmr_last)
    );

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_IDLE:    if (cmd_start) state_d = PG_COLLECT;
            PG_COLLECT: if (cs_rise) state_d = launch ? PG_COMMIT : PG_IDLE;
            PG_COMMIT:  if (slot_q == PAGE_BITS'(SLOTS - 1)) state_d = PG_WAIT;
            PG_WAIT:    if (tmr_last) state_d = PG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PG_IDLE;
        else        state_q <= state_d;
    end

    // address and position registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            ptr_q  <= '0;
            slot_q <= '0;
        end else begin
            if (st_clear) begin
                page_q <= start_addr[ADDR_W-1:PAGE_BITS];
                ptr_q  <= start_addr[PAGE_BITS-1:0];
            end else if (st_wr) begin
                ptr_q <= ptr_q + 1'b1;
            end
            if (launch)                      slot_q <= '0;
            else if (state_q == PG_COMMIT)   slot_q <= slot_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q == PG_COMMIT) || (state_q == PG_WAIT);
        arr_we     = (state_q == PG_COMMIT) && have[slot_q];
        arr_addr   = {page_q, slot_q};
        arr_wdata  = rd_data;
        tmr_run    = (state_q == PG_WAIT);
        cycle_done = tmr_last;
    end

    AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done); // R9
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !busy); // R8
    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cycle_done) |=> busy); // R8
    AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !st_wr); // R10
endmodule

// File: tb/pgbuf_prog_test.sv
module pgbuf_prog_test;
    localparam int PROG = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 0, byte_vld = 0, cs_rise = 0;
    logic       at_boundary = 1, wr_permit = 1;
    logic [7:0] start_addr = 0, byte_data = 0;
    logic       busy, arr_we, cycle_done;
    logic [7:0] arr_addr, arr_wdata;

    int checks = 0, errors = 0, dut_wr = 0;
    bit finished = 0;

    // behavioural reference model
    int m_state = 0, m_page = 0, m_ptr = 0, m_slot = 0, m_cnt = 0;
    int m_buf[4];
    bit m_have[4];
    int exp_q[$];

    always #10 clk = ~clk;

    pgbuf_prog #(.ADDR_W(8), .DATA_W(8), .PAGE_BITS(2), .PROG_CLKS(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
        .at_boundary(at_boundary), .wr_permit(wr_permit), .busy(busy),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .cycle_done(cycle_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0;
        end else begin
            case (m_state)
                0: if (cmd_start) begin
                       m_state = 1; m_page = start_addr / 4; m_ptr = start_addr % 4;
                       for (int i = 0; i < 4; i++) m_have[i] = 0;
                   end
                1: if (cs_rise) begin
                       if (at_boundary && wr_permit && (m_have[0]|m_have[1]|m_have[2]|m_have[3])) begin
                           m_state = 2; m_slot = 0;
                           for (int i = 0; i < 4; i++)
                               if (m_have[i]) exp_q.push_back((m_page*4 + i) * 256 + m_buf[i]);
                       end else m_state = 0;
                   end else if (byte_vld) begin
                       m_buf[m_ptr] = byte_data; m_have[m_ptr] = 1; m_ptr = (m_ptr + 1) % 4;
                   end
                2: if (m_slot == 3) begin m_state = 3; m_cnt = 0; end else m_slot++;
                default: if (m_cnt == PROG - 1) m_state = 0; else m_cnt++;
            endcase
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_busy, e_we, e_done;
            e_busy = (m_state == 2) || (m_state == 3);
            e_we   = (m_state == 2) && m_have[m_slot];
            e_done = (m_state == 3) && (m_cnt == PROG - 1);
            check(busy == e_busy, "R8 busy", busy, e_busy);
            check(arr_we == e_we, "R7 arr_we", arr_we, e_we);
            check(cycle_done == e_done, "R9 cycle_done", cycle_done, e_done);
            if (arr_we) begin
                int exp_v;
                dut_wr++;
                exp_v = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                check(int'(arr_addr) == exp_v / 256, "R2 arr_addr", arr_addr, exp_v / 256);
                check(int'(arr_wdata) == exp_v % 256, "R3 arr_wdata", arr_wdata, exp_v % 256);
            end
        end
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic send_cmd(input int addr, input int n, input int d0,
                            input bit perm, input bit bnd);
        tick(); cmd_start = 1; start_addr = 8'(addr);
        tick(); cmd_start = 0;
        for (int i = 0; i < n; i++) begin
            byte_vld = 1; byte_data = 8'(d0 + i); tick(); byte_vld = 0; tick();
        end
        wr_permit = perm; at_boundary = bnd; cs_rise = 1;
        tick(); cs_rise = 0; wr_permit = 1; at_boundary = 1;
    endtask

    task automatic settle();
        repeat (PROG + 10) tick();
    endtask

    initial begin
        int base;
        repeat (3) tick();
        check(busy == 0 && arr_we == 0 && cycle_done == 0, "R11 reset outputs",
              {busy, arr_we, cycle_done}, 0);
        rst_n = 1;
        tick();

        base = dut_wr; send_cmd(8'h40, 1, 8'hA5, 1, 1); settle();
        check(dut_wr - base == 1, "R1 single byte", dut_wr - base, 1);
        check(exp_q.size() == 0, "R4 launched write drained", exp_q.size(), 0);

        base = dut_wr; send_cmd(8'h52, 3, 8'h10, 1, 1); settle();
        check(dut_wr - base == 3, "R2 three bytes from mid page", dut_wr - base, 3);

        base = dut_wr; send_cmd(8'h13, 6, 8'h30, 1, 1); settle();
        check(dut_wr - base == 4, "R3 wrap keeps four positions", dut_wr - base, 4);

        base = dut_wr; send_cmd(8'hC0, 4, 8'h70, 1, 1); settle();
        check(dut_wr - base == 4, "R1 full page", dut_wr - base, 4);

        base = dut_wr; send_cmd(8'h20, 2, 8'h55, 0, 1); settle();
        check(dut_wr - base == 0, "R5 not permitted", dut_wr - base, 0);

        base = dut_wr; send_cmd(8'h24, 2, 8'h66, 1, 0); settle();
        check(dut_wr - base == 0, "R6 partial byte abort", dut_wr - base, 0);

        base = dut_wr; send_cmd(8'h28, 0, 8'h00, 1, 1); settle();
        check(dut_wr - base == 0, "R4 no byte no cycle", dut_wr - base, 0);

        // R10: stimulus while busy is ignored
        base = dut_wr; send_cmd(8'h80, 1, 8'h11, 1, 1);
        repeat (6) tick();
        check(busy == 1, "R10 busy during cycle", busy, 1);
        cmd_start = 1; start_addr = 8'h90; byte_vld = 1; byte_data = 8'hEE; cs_rise = 1;
        tick(); cmd_start = 0; byte_vld = 0; cs_rise = 0;
        settle();
        check(dut_wr - base == 1, "R10 stimulus while busy ignored", dut_wr - base, 1);

        // R12: byte strobes in IDLE do not reach the array
        base = dut_wr;
        byte_vld = 1; byte_data = 8'hBB; tick(); byte_vld = 0; tick();
        send_cmd(8'h60, 1, 8'h3C, 1, 1); settle();
        check(dut_wr - base == 1, "R12 idle byte ignored", dut_wr - base, 1);
        check(exp_q.size() == 0, "R7 all expected writes seen", exp_q.size(), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule